// File: doc/BRIEF.md
# Prescaled Sampling Strobe Generator

This block turns a free-running system clock into a one-cycle enable strobe at sixteen times the serial bit rate. A UART's transmitter uses the strobe to shift bits and its receiver uses it to sample. The strobe is an enable in the system clock domain and never a derived clock, so all of the serial logic stays on a single clock.

The rate comes from two stages in series. The first stage is a prescaler. One control input sets it to pass every clock or every fourth clock. The second stage is a down-counter with a 16-bit divisor. Software writes the divisor one byte at a time. The same divisor value therefore gives two strobe ranges, one four times slower than the other.

A low-byte write is only staged. The high-byte write commits both bytes to the divisor in one step. The counter picks up a committed divisor only when it next reloads, so the period that is running when the write arrives is never shortened or stretched. A divisor of zero stops the generator.

Top module: `sample_tick_gen`

## Requirements
- R1: While reset is held and after reset is released, `tick_o` is low and the committed divisor is zero. No strobe appears until a nonzero divisor is committed.
- R2: With `presc4_i` = 0 and a committed divisor D between 1 and 65535, consecutive strobes are exactly D clock cycles apart.
- R3: With `presc4_i` = 1 and a committed divisor D, consecutive strobes are exactly 4·D cycles apart. While `presc4_i` stays at 1, a strobe is never followed by another strobe in the next cycle.
- R4: With `presc4_i` = 0 and divisor 1, `tick_o` is high on every clock cycle.
- R5: Once a divisor of zero is committed, no strobe appears from the second cycle after the committing edge onward.
- R6: A write with `div_lo_we_i` stores `wdata_i` only as a staged low byte and leaves the strobe spacing unchanged. A write with `div_hi_we_i` commits {`wdata_i`, staged low byte} as the divisor, with the high byte in bits 15:8. If both enables are high together, only the high-byte write takes effect.
- R7: A divisor committed in the middle of a period takes effect at the next reload. The period in progress keeps its old length, and the period after it has the new length.
- R8: From the stopped state with `presc4_i` = 0, committing divisor N makes the first strobe appear N+1 cycles after the committing edge. This holds up to N = 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| presc4_i | input | 1 | Prescaler select: 0 passes every clock, 1 passes every fourth |
| div_lo_we_i | input | 1 | Stage `wdata_i` as the divisor low byte |
| div_hi_we_i | input | 1 | Commit `wdata_i` as high byte together with the staged low byte |
| wdata_i | input | 8 | Divisor byte data |
| tick_o | output | 1 | One-cycle sampling strobe at 16x the bit rate |

## Verification
The hardest case to reach from the ports is a divisor change that lands in the middle of a running period. The counter state is hidden, so a wrong reload is visible only as one interval of the wrong length. The stimulus waits for a strobe under a long divisor and writes a short divisor a fixed number of cycles later. It then measures the interval that spans the write and the interval after it. The widest divisor is reached by starting from the stopped state right after reset and timing the first strobe, which avoids waiting through several 65535-cycle periods.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic {
    PRE_DIV1 = 1'b0,
    PRE_DIV4 = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/stg_div_regs.sv
module stg_div_regs #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [BYTE_W-1:0] lo_stage_q;
  logic [DIV_W-1:0]  div_q;

  // high write commits atomically; it wins over a simultaneous low write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_stage_q <= '0;
      div_q      <= '0;
    end else if (hi_we_i) begin
      div_q <= {wdata_i[HI_W-1:0], lo_stage_q};
    end else if (lo_we_i) begin
      lo_stage_q <= wdata_i;
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/stg_prescaler.sv
module stg_prescaler
  import stg_pkg::*;
#(
  parameter int RATIO = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pre_mode_e mode_i,
  output logic      pre_en_o
);
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  generate
    if (RATIO > 1) begin : g_div
      logic [CNT_W-1:0] cnt_q;
      // free-running so a mode change never resets phase
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign pre_en_o = (mode_i == PRE_DIV1) || (cnt_q == LAST);
    end else begin : g_pass
      assign pre_en_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/stg_divider.sv
module stg_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             reload;
  logic             div_live;

  assign reload   = (cnt_q <= ONE);
  assign div_live = (div_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (pre_en_i) begin
        if (reload) begin
          cnt_q  <= div_i;   // divisor sampled only here
          tick_q <= (cnt_q == ONE) && div_live;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/sample_tick_gen.sv
module sample_tick_gen
  import stg_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int PRE_RATIO = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              presc4_i,
  input  logic              div_lo_we_i,
  input  logic              div_hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] div_w;
  logic [DIV_W-1:0] cnt_w;
  logic             pre_en_w;
  pre_mode_e        mode_w;

  assign mode_w = presc4_i ? PRE_DIV4 : PRE_DIV1;

  stg_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (div_lo_we_i),
    .hi_we_i (div_hi_we_i),
    .wdata_i (wdata_i),
    .div_o   (div_w)
  );

  stg_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_w),
    .pre_en_o (pre_en_w)
  );

  stg_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pre_en_i (pre_en_w),
    .div_i    (div_w),
    .cnt_o    (cnt_w),
    .tick_o   (tick_o)
  );
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              presc4_i,
  input logic              div_lo_we_i,
  input logic              div_hi_we_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [DIV_W-1:0]  div_i,
  input logic [DIV_W-1:0]  cnt_i,
  input logic              tick_i
);
  localparam int HI_W = DIV_W - BYTE_W;

  // R3
  presc4_no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && presc4_i && $past(presc4_i)) |=> !tick_i);

  // R5
  zero_div_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |=> !tick_i);

  // R6
  lo_write_staged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_lo_we_i && !div_hi_we_i) |=> $stable(div_i));

  // R6
  hi_write_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_hi_we_i |=> (div_i[DIV_W-1:BYTE_W] == $past(wdata_i[HI_W-1:0])));

  // R7
  reload_at_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (cnt_i == $past(div_i)));
endmodule

bind sample_tick_gen stg_checker #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .presc4_i    (presc4_i),
  .div_lo_we_i (div_lo_we_i),
  .div_hi_we_i (div_hi_we_i),
  .wdata_i     (wdata_i),
  .div_i       (div_w),
  .cnt_i       (cnt_w),
  .tick_i      (tick_o)
);

// File: tb/sample_tick_gen_test.sv
`timescale 1ns/1ps
module sample_tick_gen_test;
  localparam int LIMIT = 70000;
  localparam int NV = 7;
  localparam int V_PRE [NV] = '{0, 0, 0, 1, 1, 0, 1};
  localparam int V_DIV [NV] = '{1, 2, 7, 1, 3, 256, 261};
  localparam int V_PER [NV] = '{1, 2, 7, 4, 12, 256, 1044};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       presc4 = 1'b0;
  logic       lo_we = 1'b0;
  logic       hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic       tick;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sample_tick_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .presc4_i(presc4),
    .div_lo_we_i(lo_we), .div_hi_we_i(hi_we), .wdata_i(wdata), .tick_o(tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_div(input int v);
    @(negedge clk); lo_we = 1'b1; wdata = v[7:0];
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b1; wdata = v[15:8];
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < LIMIT);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; presc4 = 1'b0;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 tick during reset", tick, 0);
    rst_ni = 1'b1;
  endtask

  task automatic first_tick(input int n_div);
    int n;
    @(negedge clk); lo_we = 1'b1; wdata = n_div[7:0];
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b1; wdata = n_div[15:8];
    @(negedge clk); hi_we = 1'b0;
    chk(tick == 1'b0, "R8 no tick at commit", tick, 0);
    wait_tick(n);
    chk(n == n_div + 1, "R8 first strobe latency", n, n_div + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, seen;
    do_reset();
    // R1: idle after reset
    seen = 0;
    repeat (50) begin @(negedge clk); if (tick) seen++; end
    chk(seen == 0, "R1 no strobe after reset", seen, 0);

    // R8 small N from stopped state
    first_tick(5);

    // table walk: R2 / R3
    for (int i = 0; i < NV; i++) begin
      presc4 = V_PRE[i][0];
      write_div(V_DIV[i]);
      wait_tick(n); wait_tick(n);
      for (int k = 0; k < 2; k++) begin
        wait_tick(n);
        chk(n == V_PER[i], V_PRE[i] ? "R3 prescale-4 interval" : "R2 prescale-1 interval",
            n, V_PER[i]);
      end
    end

    // R4: every cycle
    presc4 = 1'b0;
    write_div(1);
    wait_tick(n); wait_tick(n);
    seen = 0;
    repeat (8) begin @(negedge clk); if (tick) seen++; end
    chk(seen == 8, "R4 strobe each cycle", seen, 8);

    // R6: low write alone has no effect
    write_div(8);
    wait_tick(n); wait_tick(n);
    @(negedge clk); lo_we = 1'b1; wdata = 8'd3;
    @(negedge clk); lo_we = 1'b0;
    wait_tick(n); wait_tick(n);
    chk(n == 8, "R6 staged low byte ignored", n, 8);
    @(negedge clk); hi_we = 1'b1; wdata = 8'd0;
    @(negedge clk); hi_we = 1'b0;
    wait_tick(n); wait_tick(n); wait_tick(n);
    chk(n == 3, "R6 high write commits staged low", n, 3);
    // R6: simultaneous enables -> high only
    @(negedge clk); lo_we = 1'b1; wdata = 8'd5;
    @(negedge clk); lo_we = 1'b1; hi_we = 1'b1; wdata = 8'd0;
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b0;
    wait_tick(n); wait_tick(n); wait_tick(n);
    chk(n == 5, "R6 simultaneous write high wins", n, 5);

    // R7: change mid-period
    write_div(40);
    wait_tick(n); wait_tick(n);
    n = 0;
    repeat (10) begin @(negedge clk); n++; end
    @(negedge clk); n++; lo_we = 1'b1; wdata = 8'd6;
    @(negedge clk); n++; lo_we = 1'b0; hi_we = 1'b1; wdata = 8'd0;
    @(negedge clk); n++; hi_we = 1'b0;
    while (!tick && n < LIMIT) begin @(negedge clk); n++; end
    chk(n == 40, "R7 running period keeps old length", n, 40);
    wait_tick(n);
    chk(n == 6, "R7 next period uses new divisor", n, 6);

    // R5: zero stops
    write_div(0);
    seen = 0;
    repeat (300) begin @(negedge clk); if (tick) seen++; end
    chk(seen == 0, "R5 zero divisor stops strobes", seen, 0);

    // R8 largest divisor
    do_reset();
    first_tick(65535);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule